// File: doc/BRIEF.md
# Vector Operand Swizzle and Writemask Router

This block sits between the register files of a four-lane vector ALU and the ALU itself. On the read side, each of three source operands names a register file and an index. The first or the second source can have an address-register offset added to its index. The four lanes of the fetched vector are then reordered by per-lane selectors and can be sign-flipped as a group. On the write side, a result vector goes to the output file, to the temporary file, or nowhere, depending on the range of the destination index. A four-bit lane mask decides which lanes are written.

The selectors, negate flags and lane mask for an instruction come from a small pattern table. Software loads the table through a write port, and each instruction picks an entry by its descriptor id. The register files are outside the block. The block drives a read kind and a read index for each source, and the register files return the vector data in the same cycle. Lanes are 24-bit floats with the sign in bit 23. Results are registered once.

Top module: `vec_operand_router`

## Requirements
- R1: While rst_ni is low and after its release, before any stimulus: opnd_valid_o is 0, opnd_o is all zero, and out_we_o and tmp_we_o are both 0.
- R2: A write with pat_we_i=1 stores pat_wdata_i at pat_waddr_i at the clock edge. Issues and writebacks that use that id afterwards see the new entry. Entry layout: bits [3:0] are the lane mask. Source s (0..2) has its negate flag at bit 4+9s and its selector for lane i at bits 5+9s+2i and 6+9s+2i.
- R3: Lane i of an operand is the source lane picked by the selector for lane i (0=x at bits [23:0], 1=y, 2=z, 3=w at bits [95:72]). Each source is swizzled on its own. The operands appear on opnd_o (source s at bits [96s+95:96s]) with opnd_valid_o=1 one cycle after issue_i. opnd_o holds between issues.
- R4: When a source's negate flag is set, bit 23 of all four of its swizzled lanes is inverted. The other bits are unchanged.
- R5: rd_kind_o repeats src_kind_i in the same cycle. Kind 0 is the input file, 1 the temporary file and 2 the float-uniform file. Kind 3 gives an all-zero vector whatever rd_data_i holds. Negation is applied to that zero, so each lane becomes 0x800000.
- R6: addr_sel_i=1 adds addr0_i to the offset source index and addr_sel_i=2 adds addr1_i. Values 0 and 3 add nothing. The sum wraps modulo 128 and appears on rd_idx_o in the same cycle.
- R7: The offset goes to source 0 when src_inv_i=0 and to source 1 when src_inv_i=1. Source 2 never takes an offset.
- R8: One cycle after wb_valid_i, a destination below 0x10 raises out_we_o with wr_idx_o=dest. A destination from 0x10 to 0x1F raises tmp_we_o with wr_idx_o=dest-0x10. Any higher destination raises neither. wr_data_o carries wb_data_i.
- R9: The raised enable equals the lane mask of the selected entry, so lanes whose mask bit is clear keep their old value in the file.
- R10: In a cycle after wb_valid_i was 0, out_we_o and tmp_we_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_we_i | input | 1 | Pattern table write enable |
| pat_waddr_i | input | 4 | Pattern table write address |
| pat_wdata_i | input | 31 | Pattern entry to store |
| issue_i | input | 1 | Form operands this cycle |
| desc_id_i | input | 4 | Pattern entry for the issue |
| src_kind_i | input | 6 | Register kind per source, 2 bits each |
| src_idx_i | input | 21 | Register index per source, 7 bits each |
| addr_sel_i | input | 2 | Address register choice for the offset |
| src_inv_i | input | 1 | Moves the offset from source 0 to source 1 |
| addr0_i | input | 7 | First address register |
| addr1_i | input | 7 | Second address register |
| rd_kind_o | output | 6 | Read request kind per source |
| rd_idx_o | output | 21 | Read request index per source, offset applied |
| rd_data_i | input | 288 | Vectors returned for the read requests |
| opnd_valid_o | output | 1 | Operands valid |
| opnd_o | output | 288 | Swizzled and negated operands |
| wb_valid_i | input | 1 | Writeback request |
| wb_desc_id_i | input | 4 | Pattern entry giving the lane mask |
| wb_dest_i | input | 7 | Destination index |
| wb_data_i | input | 96 | Result vector |
| out_we_o | output | 4 | Per-lane write enable, output file |
| tmp_we_o | output | 4 | Per-lane write enable, temporary file |
| wr_idx_o | output | 4 | Index within the selected file |
| wr_data_o | output | 96 | Result vector to write |

## Verification
Read kinds and offset indices are combinational, so the bench checks them one time step after it drives an issue at the falling edge. Operands, lane enables, write index and write data are each one register deep. The bench checks them at the next falling edge, one rising edge after the stimulus, and only then withdraws the request. Lane masking is also checked one full cycle later, after the bench's file model has taken the enabled lanes, by comparing the file entry with the merge that the requirements predict.

// File: rtl/vor_pkg.sv
package vor_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned LANES   = 4;

  typedef enum logic [1:0] {
    KIND_IN   = 2'd0,
    KIND_TMP  = 2'd1,
    KIND_UNI  = 2'd2,
    KIND_NONE = 2'd3
  } src_kind_e;

  typedef struct packed {
    logic [LANES-1:0][1:0] sel;
    logic                  neg;
  } src_desc_t;

  typedef struct packed {
    src_desc_t [NUM_SRC-1:0] src;
    logic [LANES-1:0]        mask;
  } pattern_t;

  localparam int unsigned PAT_W = $bits(pattern_t);
endpackage

// File: rtl/vor_pattern_table.sv
module vor_pattern_table
  import vor_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  pattern_t      wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output pattern_t      rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output pattern_t      rdata_b_o
);
  pattern_t tbl_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) tbl_q[e] <= '0;
    end else if (we_i) begin
      tbl_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = tbl_q[raddr_a_i];
  assign rdata_b_o = tbl_q[raddr_b_i];
endmodule

// File: rtl/vor_src_former.sv
module vor_src_former
  import vor_pkg::*;
#(
  parameter int unsigned COMP_W = 24,
  parameter int unsigned IDX_W  = 7,
  localparam int unsigned VEC_W = LANES * COMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] ofs_i,
  input  src_desc_t        desc_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [VEC_W-1:0] rd_data_i,
  output logic [VEC_W-1:0] opnd_o
);
  logic [VEC_W-1:0] swz;
  logic [VEC_W-1:0] opnd_q;

  assign rd_idx_o = idx_i + ofs_i;

  always_comb begin
    swz = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      logic [COMP_W-1:0] c;
      c = rd_data_i[int'(desc_i.sel[i])*COMP_W +: COMP_W];
      if (kind_i == KIND_NONE) c = '0;
      c[COMP_W-1] = c[COMP_W-1] ^ desc_i.neg;
      swz[i*COMP_W +: COMP_W] = c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opnd_q <= '0;
    else if (issue_i) opnd_q <= swz;
  end

  assign opnd_o = opnd_q;
endmodule

// File: rtl/vor_wb_steer.sv
module vor_wb_steer
  import vor_pkg::*;
#(
  parameter int unsigned COMP_W     = 24,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned FILE_DEPTH = 16,
  localparam int unsigned FAW       = $clog2(FILE_DEPTH),
  localparam int unsigned VEC_W     = LANES * COMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] dest_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [VEC_W-1:0] data_i,
  output logic [LANES-1:0] out_we_o,
  output logic [LANES-1:0] tmp_we_o,
  output logic [FAW-1:0]   wr_idx_o,
  output logic [VEC_W-1:0] wr_data_o
);
  localparam logic [IDX_W-1:0] TMP_BASE = IDX_W'(FILE_DEPTH);
  localparam logic [IDX_W-1:0] LIMIT    = IDX_W'(2 * FILE_DEPTH);

  logic             hit_out, hit_tmp;
  logic [LANES-1:0] out_we_q, tmp_we_q;
  logic [FAW-1:0]   idx_q;
  logic [VEC_W-1:0] data_q;

  assign hit_out = valid_i && (dest_i < TMP_BASE);
  assign hit_tmp = valid_i && (dest_i >= TMP_BASE) && (dest_i < LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_we_q <= '0;
      tmp_we_q <= '0;
      idx_q    <= '0;
      data_q   <= '0;
    end else begin
      out_we_q <= hit_out ? mask_i : '0;
      tmp_we_q <= hit_tmp ? mask_i : '0;
      if (valid_i) begin
        idx_q  <= dest_i[FAW-1:0];  // both bases are multiples of FILE_DEPTH
        data_q <= data_i;
      end
    end
  end

  assign out_we_o  = out_we_q;
  assign tmp_we_o  = tmp_we_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/vec_operand_router.sv
module vec_operand_router
  import vor_pkg::*;
#(
  parameter int unsigned COMP_W     = 24,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned PAT_DEPTH  = 16,
  parameter int unsigned FILE_DEPTH = 16,
  localparam int unsigned PAW       = $clog2(PAT_DEPTH),
  localparam int unsigned FAW       = $clog2(FILE_DEPTH),
  localparam int unsigned VEC_W     = LANES * COMP_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pat_we_i,
  input  logic [PAW-1:0]             pat_waddr_i,
  input  logic [PAT_W-1:0]           pat_wdata_i,
  input  logic                       issue_i,
  input  logic [PAW-1:0]             desc_id_i,
  input  logic [NUM_SRC*2-1:0]       src_kind_i,
  input  logic [NUM_SRC*IDX_W-1:0]   src_idx_i,
  input  logic [1:0]                 addr_sel_i,
  input  logic                       src_inv_i,
  input  logic [IDX_W-1:0]           addr0_i,
  input  logic [IDX_W-1:0]           addr1_i,
  output logic [NUM_SRC*2-1:0]       rd_kind_o,
  output logic [NUM_SRC*IDX_W-1:0]   rd_idx_o,
  input  logic [NUM_SRC*VEC_W-1:0]   rd_data_i,
  output logic                       opnd_valid_o,
  output logic [NUM_SRC*VEC_W-1:0]   opnd_o,
  input  logic                       wb_valid_i,
  input  logic [PAW-1:0]             wb_desc_id_i,
  input  logic [IDX_W-1:0]           wb_dest_i,
  input  logic [VEC_W-1:0]           wb_data_i,
  output logic [LANES-1:0]           out_we_o,
  output logic [LANES-1:0]           tmp_we_o,
  output logic [FAW-1:0]             wr_idx_o,
  output logic [VEC_W-1:0]           wr_data_o
);
  pattern_t         iss_pat, wb_pat;
  logic [IDX_W-1:0] ofs_val;
  logic             valid_q;

  vor_pattern_table #(.DEPTH(PAT_DEPTH)) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (pat_we_i),
    .waddr_i   (pat_waddr_i),
    .wdata_i   (pattern_t'(pat_wdata_i)),
    .raddr_a_i (desc_id_i),
    .rdata_a_o (iss_pat),
    .raddr_b_i (wb_desc_id_i),
    .rdata_b_o (wb_pat)
  );

  always_comb begin
    unique case (addr_sel_i)
      2'd1:    ofs_val = addr0_i;
      2'd2:    ofs_val = addr1_i;
      default: ofs_val = '0;
    endcase
  end

  assign rd_kind_o = src_kind_i;

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_src
    logic [IDX_W-1:0] ofs_s;
    // offset sits on source 0, or on source 1 when inverted
    assign ofs_s = ((s == 0 && !src_inv_i) || (s == 1 && src_inv_i)) ? ofs_val : '0;

    vor_src_former #(.COMP_W(COMP_W), .IDX_W(IDX_W)) u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (issue_i),
      .kind_i    (src_kind_i[s*2 +: 2]),
      .idx_i     (src_idx_i[s*IDX_W +: IDX_W]),
      .ofs_i     (ofs_s),
      .desc_i    (iss_pat.src[s]),
      .rd_idx_o  (rd_idx_o[s*IDX_W +: IDX_W]),
      .rd_data_i (rd_data_i[s*VEC_W +: VEC_W]),
      .opnd_o    (opnd_o[s*VEC_W +: VEC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= issue_i;
  end
  assign opnd_valid_o = valid_q;

  vor_wb_steer #(
    .COMP_W(COMP_W), .IDX_W(IDX_W), .FILE_DEPTH(FILE_DEPTH)
  ) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (wb_valid_i),
    .dest_i    (wb_dest_i),
    .mask_i    (wb_pat.mask),
    .data_i    (wb_data_i),
    .out_we_o  (out_we_o),
    .tmp_we_o  (tmp_we_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/vor_chk.sv
module vor_chk #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned NUM_SRC    = 3,
  parameter int unsigned FILE_DEPTH = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     issue_i,
  input logic                     opnd_valid_o,
  input logic                     wb_valid_i,
  input logic [IDX_W-1:0]         wb_dest_i,
  input logic [3:0]               out_we_o,
  input logic [3:0]               tmp_we_o,
  input logic [1:0]               addr_sel_i,
  input logic [NUM_SRC*IDX_W-1:0] src_idx_i,
  input logic [NUM_SRC*IDX_W-1:0] rd_idx_o
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(2 * FILE_DEPTH);

  // R3
  valid_follows_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_valid_o == $past(issue_i));

  // R6
  no_offset_when_unselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_sel_i == 2'd0) |-> (rd_idx_o == src_idx_i));

  // R7
  third_source_unshifted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_o[2*IDX_W +: IDX_W] == src_idx_i[2*IDX_W +: IDX_W]);

  // R8
  single_file_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((out_we_o != 4'd0) && (tmp_we_o != 4'd0)));

  // R8
  discard_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_dest_i >= LIMIT) |=> (out_we_o == 4'd0 && tmp_we_o == 4'd0));

  // R10
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |=> (out_we_o == 4'd0 && tmp_we_o == 4'd0));
endmodule

bind vec_operand_router vor_chk #(
  .IDX_W(IDX_W), .NUM_SRC(vor_pkg::NUM_SRC), .FILE_DEPTH(FILE_DEPTH)
) u_vor_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_i      (issue_i),
  .opnd_valid_o (opnd_valid_o),
  .wb_valid_i   (wb_valid_i),
  .wb_dest_i    (wb_dest_i),
  .out_we_o     (out_we_o),
  .tmp_we_o     (tmp_we_o),
  .addr_sel_i   (addr_sel_i),
  .src_idx_i    (src_idx_i),
  .rd_idx_o     (rd_idx_o)
);

// File: tb/vec_operand_router_bench.sv
`timescale 1ns/1ps
module vec_operand_router_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pat_we_i = 1'b0;
  logic [3:0]   pat_waddr_i = '0;
  logic [30:0]  pat_wdata_i = '0;
  logic         issue_i = 1'b0;
  logic [3:0]   desc_id_i = '0;
  logic [5:0]   src_kind_i = '0;
  logic [20:0]  src_idx_i = '0;
  logic [1:0]   addr_sel_i = '0;
  logic         src_inv_i = 1'b0;
  logic [6:0]   addr0_i = '0, addr1_i = '0;
  logic [5:0]   rd_kind_o;
  logic [20:0]  rd_idx_o;
  logic [287:0] rd_data_i;
  logic         opnd_valid_o;
  logic [287:0] opnd_o;
  logic         wb_valid_i = 1'b0;
  logic [3:0]   wb_desc_id_i = '0;
  logic [6:0]   wb_dest_i = '0;
  logic [95:0]  wb_data_i = '0;
  logic [3:0]   out_we_o, tmp_we_o, wr_idx_o;
  logic [95:0]  wr_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [95:0] in_f [128];
  logic [95:0] tmp_f [128];
  logic [95:0] uni_f [128];
  logic [95:0] out_f [16];
  logic [30:0] pat_m [16];

  always #2 clk_i = ~clk_i;

  vec_operand_router u_vec_operand_router (.*);

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      case (rd_kind_o[s*2 +: 2])
        2'd0:    rd_data_i[s*96 +: 96] = in_f[rd_idx_o[s*7 +: 7]];
        2'd1:    rd_data_i[s*96 +: 96] = tmp_f[rd_idx_o[s*7 +: 7]];
        2'd2:    rd_data_i[s*96 +: 96] = uni_f[rd_idx_o[s*7 +: 7]];
        default: rd_data_i[s*96 +: 96] = {4{24'h5A5A5A}};
      endcase
    end
  end

  always @(posedge clk_i) begin
    for (int c = 0; c < 4; c++) begin
      if (out_we_o[c]) out_f[wr_idx_o][c*24 +: 24] <= wr_data_o[c*24 +: 24];
      if (tmp_we_o[c]) tmp_f[wr_idx_o][c*24 +: 24] <= wr_data_o[c*24 +: 24];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] mk_pat(input logic [3:0] mask,
      input logic [7:0] s0, input logic n0, input logic [7:0] s1, input logic n1,
      input logic [7:0] s2, input logic n2);
    return {s2, n2, s1, n1, s0, n0, mask};
  endfunction

  function automatic logic [95:0] exp_src(input logic [1:0] kind, input logic [6:0] idx,
                                          input logic [8:0] d);
    logic [95:0] v, r;
    case (kind)
      2'd0: v = in_f[idx];
      2'd1: v = tmp_f[idx];
      2'd2: v = uni_f[idx];
      default: v = '0;
    endcase
    for (int i = 0; i < 4; i++) begin
      logic [23:0] c;
      c = v[int'(d[1 + 2*i +: 2])*24 +: 24];
      c[23] = c[23] ^ d[0];
      r[i*24 +: 24] = c;
    end
    return r;
  endfunction

  task automatic load_pat(input logic [3:0] id, input logic [30:0] val);
    @(negedge clk_i);
    pat_we_i = 1'b1; pat_waddr_i = id; pat_wdata_i = val;
    @(negedge clk_i);
    pat_we_i = 1'b0;
    pat_m[id] = val;
  endtask

  task automatic do_issue(input logic [3:0] d, input logic [5:0] k, input logic [20:0] ix,
                          input logic [1:0] as, input logic inv, input logic [6:0] a0,
                          input logic [6:0] a1, input string tag);
    logic [6:0] ofs, eidx;
    logic [95:0] eop [3];
    @(negedge clk_i);
    issue_i = 1'b1; desc_id_i = d; src_kind_i = k; src_idx_i = ix;
    addr_sel_i = as; src_inv_i = inv; addr0_i = a0; addr1_i = a1;
    #1;
    ofs = (as == 2'd1) ? a0 : (as == 2'd2) ? a1 : 7'd0;
    chk(rd_kind_o == k, {tag, " R5 kind"}, 96'(rd_kind_o), 96'(k));
    for (int s = 0; s < 3; s++) begin
      eidx = ix[s*7 +: 7] + (((s == 0 && !inv) || (s == 1 && inv)) ? ofs : 7'd0);
      chk(rd_idx_o[s*7 +: 7] == eidx, {tag, " R6 R7 index"}, 96'(rd_idx_o[s*7 +: 7]), 96'(eidx));
      eop[s] = exp_src(k[s*2 +: 2], eidx, pat_m[d][4 + 9*s +: 9]);
    end
    @(negedge clk_i);
    chk(opnd_valid_o, {tag, " R3 valid"}, 96'(opnd_valid_o), 96'd1);
    for (int s = 0; s < 3; s++)
      chk(opnd_o[s*96 +: 96] == eop[s], {tag, " operand"}, opnd_o[s*96 +: 96], eop[s]);
    issue_i = 1'b0;
  endtask

  task automatic do_wb(input logic [3:0] d, input logic [6:0] dest, input logic [95:0] data,
                       input string tag);
    logic [3:0] m, eo, et;
    @(negedge clk_i);
    wb_valid_i = 1'b1; wb_desc_id_i = d; wb_dest_i = dest; wb_data_i = data;
    m  = pat_m[d][3:0];
    eo = (dest < 7'h10) ? m : 4'd0;
    et = (dest >= 7'h10 && dest < 7'h20) ? m : 4'd0;
    @(negedge clk_i);
    chk(out_we_o == eo, {tag, " R8 R9 out_we"}, 96'(out_we_o), 96'(eo));
    chk(tmp_we_o == et, {tag, " R8 R9 tmp_we"}, 96'(tmp_we_o), 96'(et));
    if (dest < 7'h20) begin
      chk(wr_idx_o == dest[3:0], {tag, " R8 wr_idx"}, 96'(wr_idx_o), 96'(dest[3:0]));
      chk(wr_data_o == data, {tag, " R8 wr_data"}, wr_data_o, data);
    end
    wb_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [95:0] old, merged;
    void'($urandom(32'd4242));
    for (int e = 0; e < 128; e++) begin
      in_f[e]  = {$urandom, $urandom, $urandom};
      tmp_f[e] = {$urandom, $urandom, $urandom};
      uni_f[e] = {$urandom, $urandom, $urandom};
    end
    for (int e = 0; e < 16; e++) begin out_f[e] = '0; pat_m[e] = '0; end

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!opnd_valid_o && opnd_o == '0, "R1 operands", 96'(opnd_valid_o), 96'd0);
    chk(out_we_o == 4'd0 && tmp_we_o == 4'd0, "R1 enables", 96'({out_we_o, tmp_we_o}), 96'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!opnd_valid_o && out_we_o == 4'd0 && tmp_we_o == 4'd0, "R1 after release",
        96'({opnd_valid_o, out_we_o, tmp_we_o}), 96'd0);

    // identity, reverse and broadcast swizzles (R3), negate on one source (R4)
    load_pat(4'd1, mk_pat(4'hF, 8'hE4, 1'b0, 8'h1B, 1'b0, 8'hAA, 1'b1));
    do_issue(4'd1, 6'b00_01_10, {7'd9, 7'd40, 7'd3}, 2'd0, 1'b0, 7'd0, 7'd0, "R3 R4 mix");
    // R2 overwrite of the same entry takes effect
    load_pat(4'd1, mk_pat(4'h3, 8'h00, 1'b1, 8'hFF, 1'b0, 8'hE4, 1'b0));
    do_issue(4'd1, 6'b00_00_00, {7'd1, 7'd2, 7'd3}, 2'd0, 1'b0, 7'd0, 7'd0, "R2 reload");
    // R5 none kind: zero, and 0x800000 lanes when negated
    load_pat(4'd2, mk_pat(4'hF, 8'hE4, 1'b0, 8'hE4, 1'b1, 8'hE4, 1'b0));
    do_issue(4'd2, 6'b10_11_11, {7'd77, 7'd5, 7'd6}, 2'd0, 1'b0, 7'd0, 7'd0, "R5 none");
    // R6 R7 offsets
    do_issue(4'd2, 6'b01_00_10, {7'd10, 7'd20, 7'd30}, 2'd1, 1'b0, 7'd5, 7'd9, "R6 a0 src0");
    do_issue(4'd2, 6'b01_00_10, {7'd10, 7'd20, 7'd30}, 2'd2, 1'b1, 7'd5, 7'd9, "R7 a1 src1");
    do_issue(4'd2, 6'b01_00_10, {7'd10, 7'd20, 7'd30}, 2'd3, 1'b0, 7'd5, 7'd9, "R6 sel3 none");
    do_issue(4'd2, 6'b00_00_00, {7'd0, 7'd0, 7'd120}, 2'd1, 1'b0, 7'd20, 7'd0, "R6 wrap");
    // R3 operands hold while idle
    old = opnd_o[95:0];
    @(negedge clk_i);
    chk(!opnd_valid_o && opnd_o[95:0] == old, "R3 hold", opnd_o[95:0], old);

    // writeback
    load_pat(4'd3, mk_pat(4'hF, 8'hE4, 1'b0, 8'hE4, 1'b0, 8'hE4, 1'b0));
    load_pat(4'd4, mk_pat(4'h5, 8'hE4, 1'b0, 8'hE4, 1'b0, 8'hE4, 1'b0));
    do_wb(4'd3, 7'h0F, {24'h111111, 24'h222222, 24'h333333, 24'h444444}, "R8 out top");
    chk(out_f[15] == {24'h111111, 24'h222222, 24'h333333, 24'h444444}, "R8 out file",
        out_f[15], {24'h111111, 24'h222222, 24'h333333, 24'h444444});
    old = tmp_f[5];
    merged = {old[95:72], 24'hBBBBBB, old[47:24], 24'hDDDDDD};
    do_wb(4'd4, 7'h15, {24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, 24'hDDDDDD}, "R9 mask");
    chk(tmp_f[5] == merged, "R9 kept lanes", tmp_f[5], merged);
    do_issue(4'd3, 6'b00_00_01, {7'd0, 7'd0, 7'd5}, 2'd0, 1'b0, 7'd0, 7'd0, "R9 readback");
    chk(opnd_o[95:0] == merged, "R9 readback value", opnd_o[95:0], merged);
    do_wb(4'd3, 7'h10, {4{24'h0F0F0F}}, "R8 tmp base");
    do_wb(4'd3, 7'h20, {4{24'h777777}}, "R8 discard 0x20");
    do_wb(4'd3, 7'h7F, {4{24'h777777}}, "R8 discard 0x7F");
    // R10 nothing written while wb_valid_i low
    @(negedge clk_i);
    chk(out_we_o == 4'd0 && tmp_we_o == 4'd0, "R10 idle", 96'({out_we_o, tmp_we_o}), 96'd0);

    // random patterns and operand requests
    for (int e = 0; e < 16; e++) load_pat(4'(e), 31'($urandom));
    for (int n = 0; n < 60; n++)
      do_issue(4'($urandom), 6'($urandom), 21'($urandom), 2'($urandom), 1'($urandom),
               7'($urandom), 7'($urandom), "R3 R4 R6 random");
    for (int n = 0; n < 20; n++)
      do_wb(4'($urandom), 7'($urandom % 48), {$urandom, $urandom, $urandom}, "R8 R9 random");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule